// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This unit turns a register number into the predicate mask that governs a vectorised operation on that register. It holds a small store of predication entries. Each entry names a register that is to be predicated, says whether that register lives in the integer or the floating-point file, and names the integer register that holds the mask bits. On request the unit rebuilds two 32-slot lookup tables from this store, one for integer operands and one for floating-point operands, walking the entries in index order.

Issue logic presents a register number and a floating-point flag. The unit looks up the slot, drives the read address of an integer register file read port with the mask register recorded there, and optionally inverts the returned word. One cycle later it presents the effective mask and the slot's zeroing flag, which tells the element issue logic to zero inactive elements rather than skip them. A register with no enabled slot gets an all-ones mask, so every element is active. The mask always comes from the integer register file, including for floating-point operations.

Top module: `predMaskLookup`

## Requirements
- R1: After reset `busy` and `outValid` are low, every entry reads as all-zero fields, and every table slot is disabled.
- R2: A write with `wrEn` high while `busy` is low stores all five entry fields at `wrIdx`; a write while `busy` is high is ignored.
- R3: `rebuildStart` sampled while `busy` is low disables all 64 slots and raises `busy` for exactly NUM_ENTRIES cycles starting the next cycle; `rebuildStart` while `busy` is high is ignored.
- R4: During a rebuild the entries are applied in ascending index order, one per cycle, so a later entry with the same table and key overrides an earlier one; an entry left at its reset value enables integer slot 0 with mask register 0.
- R5: The entry type bit picks the table (0 integer, 1 floating point) and `lkIsFp` picks the table for a lookup; the same key in the two tables is held independently.
- R6: A lookup of a disabled slot returns an all-ones mask and a zeroing flag of 0.
- R7: For an enabled slot `intRdAddr` equals the slot's mask register in the same cycle, and with inversion off the returned mask equals `intRdData`, for integer and floating-point lookups alike.
- R8: For an enabled slot with the invert flag set, the returned mask is the bitwise complement of `intRdData`.
- R9: The returned `outZero` equals the zeroing flag of an enabled slot.
- R10: `outValid` is high exactly in the cycle after a cycle with `lkValid` high and `busy` low; lookups while `busy` is high produce no result.
- R11: Writing an entry does not change any lookup result until the next rebuild has run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | $clog2(NUM_ENTRIES) | Entry index to write |
| wrIsFp | input | 1 | Entry type: 0 integer table, 1 floating-point table |
| wrKey | input | 5 | Register to be predicated |
| wrMaskReg | input | 5 | Integer register holding the mask |
| wrInv | input | 1 | Invert the fetched mask |
| wrZero | input | 1 | Zero inactive elements |
| rebuildStart | input | 1 | Start a table rebuild |
| busy | output | 1 | Rebuild in progress |
| lkValid | input | 1 | Lookup request |
| lkIsFp | input | 1 | Lookup is for a floating-point operand |
| lkReg | input | 5 | Operand register number |
| intRdAddr | output | 5 | Integer register file read address |
| intRdData | input | XLEN | Integer register file read data, same cycle |
| outValid | output | 1 | Result valid |
| outMask | output | XLEN | Effective predicate mask |
| outZero | output | 1 | Zeroing flag of the looked-up slot |

## Verification
The assertions assume the register file read port answers combinationally in the cycle its address is driven, and that `rebuildStart`, `wrEn` and `lkValid` are clean one-bit levels after reset. The bench holds a static register file whose contents are a fixed function of the address, so the read data is always defined. Stimulus deliberately issues rebuild starts, entry writes and lookups while a rebuild is running, to exercise the ignore and drop rules rather than avoid them.

// File: rtl/predMaskPkg.sv
package predMaskPkg;
  localparam int REG_W = 5;
  localparam int TAB_W = REG_W + 1;
  localparam int NUM_TAB = 1 << TAB_W;

  typedef struct packed {
    logic             isFp;
    logic [REG_W-1:0] key;
    logic [REG_W-1:0] maskReg;
    logic             inv;
    logic             zero;
  } predEntryT;

  typedef struct packed {
    logic             en;
    logic [REG_W-1:0] maskReg;
    logic             inv;
    logic             zero;
  } slotT;

  typedef struct packed {
    logic clearTable;
    logic applyEntry;
    logic entryWrite;
    logic lookupFire;
  } ctrlStrobeT;
endpackage

// File: rtl/predMaskCtrl.sv
module predMaskCtrl
  import predMaskPkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rebuildStart,
  input  logic             wrEn,
  input  logic             lkValid,
  output logic             busy,
  output logic [IDX_W-1:0] cursor,
  output ctrlStrobeT       strobe
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cursor <= '0;
    end else if (busy) begin
      if (cursor == LAST) begin
        busy   <= 1'b0;
        cursor <= '0;
      end else begin
        cursor <= cursor + 1'b1;
      end
    end else if (rebuildStart) begin
      busy   <= 1'b1;
      cursor <= '0;
    end
  end

  always_comb begin
    strobe.clearTable = rebuildStart && !busy;
    strobe.applyEntry = busy;
    strobe.entryWrite = wrEn && !busy;
    strobe.lookupFire = lkValid && !busy;
  end
endmodule

// File: rtl/predMaskDatapath.sv
module predMaskDatapath
  import predMaskPkg::*;
#(
  parameter int XLEN = 64,
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [IDX_W-1:0] cursor,
  input  logic [IDX_W-1:0] wrIdx,
  input  predEntryT        wrEntry,
  input  logic             lkIsFp,
  input  logic [REG_W-1:0] lkReg,
  output logic [REG_W-1:0] intRdAddr,
  input  logic [XLEN-1:0]  intRdData,
  output logic             outValid,
  output logic [XLEN-1:0]  outMask,
  output logic             outZero
);
  predEntryT entries [NUM_ENTRIES];
  slotT      slotArr [NUM_TAB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) entries[i] <= '0;
    end else if (strobe.entryWrite) begin
      entries[wrIdx] <= wrEntry;
    end
  end

  predEntryT             curEntry;
  logic      [TAB_W-1:0] applyKey;
  assign curEntry = entries[cursor];
  assign applyKey = {curEntry.isFp, curEntry.key};

  for (genvar g = 0; g < NUM_TAB; g++) begin : gSlot
    slotT slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strobe.clearTable) begin
        slotQ <= '0;
      end else if (strobe.applyEntry && applyKey == TAB_W'(g)) begin
        slotQ <= '{en: 1'b1, maskReg: curEntry.maskReg,
                   inv: curEntry.inv, zero: curEntry.zero};
      end
    end
    assign slotArr[g] = slotQ;
  end

  slotT            sel;
  logic [XLEN-1:0] fetched;
  assign sel       = slotArr[{lkIsFp, lkReg}];
  assign intRdAddr = sel.en ? sel.maskReg : '0;
  assign fetched   = sel.inv ? ~intRdData : intRdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outMask  <= '0;
      outZero  <= 1'b0;
    end else begin
      outValid <= strobe.lookupFire;
      if (strobe.lookupFire) begin
        outMask <= sel.en ? fetched : '1;
        outZero <= sel.en & sel.zero;
      end
    end
  end
endmodule

// File: rtl/predMaskLookup.sv
module predMaskLookup
  import predMaskPkg::*;
#(
  parameter int XLEN = 64,
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrIsFp,
  input  logic [REG_W-1:0] wrKey,
  input  logic [REG_W-1:0] wrMaskReg,
  input  logic             wrInv,
  input  logic             wrZero,
  input  logic             rebuildStart,
  output logic             busy,
  input  logic             lkValid,
  input  logic             lkIsFp,
  input  logic [REG_W-1:0] lkReg,
  output logic [REG_W-1:0] intRdAddr,
  input  logic [XLEN-1:0]  intRdData,
  output logic             outValid,
  output logic [XLEN-1:0]  outMask,
  output logic             outZero
);
  ctrlStrobeT       strobe;
  logic [IDX_W-1:0] cursor;
  predEntryT        wrEntry;

  assign wrEntry = '{isFp: wrIsFp, key: wrKey, maskReg: wrMaskReg,
                     inv: wrInv, zero: wrZero};

  predMaskCtrl #(.NUM_ENTRIES(NUM_ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .rebuildStart(rebuildStart), .wrEn(wrEn),
    .lkValid(lkValid), .busy(busy), .cursor(cursor), .strobe(strobe)
  );

  predMaskDatapath #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cursor(cursor),
    .wrIdx(wrIdx), .wrEntry(wrEntry), .lkIsFp(lkIsFp), .lkReg(lkReg),
    .intRdAddr(intRdAddr), .intRdData(intRdData), .outValid(outValid),
    .outMask(outMask), .outZero(outZero)
  );
endmodule

// File: rtl/predMaskLookupChk.sv
module predMaskLookupChk #(
  parameter int NUM_ENTRIES = 16
) (
  input logic clk,
  input logic rstN,
  input logic rebuildStart,
  input logic busy,
  input logic lkValid,
  input logic outValid
);
  localparam int CW = $clog2(NUM_ENTRIES + 1) + 1;
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else       busyCnt <= busy ? busyCnt + 1'b1 : '0;
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (rebuildStart && !busy) |=> busy); // R3
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyCnt == CW'(NUM_ENTRIES)); // R3
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyCnt < CW'(NUM_ENTRIES)); // R3
  AST_NO_RESULT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !outValid); // R10
  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !busy) |=> outValid); // R10
  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !outValid); // R10
endmodule

bind predMaskLookup predMaskLookupChk #(.NUM_ENTRIES(NUM_ENTRIES)) uChk (
  .clk(clk), .rstN(rstN), .rebuildStart(rebuildStart), .busy(busy),
  .lkValid(lkValid), .outValid(outValid)
);

// File: tb/tb_predMaskLookup.sv
module tb_predMaskLookup;
  localparam int XLEN = 64;
  localparam int NE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrIdx = '0;
  logic wrIsFp = 1'b0, wrInv = 1'b0, wrZero = 1'b0;
  logic [4:0] wrKey = '0, wrMaskReg = '0;
  logic rebuildStart = 1'b0;
  logic busy;
  logic lkValid = 1'b0, lkIsFp = 1'b0;
  logic [4:0] lkReg = '0;
  logic [4:0] intRdAddr;
  logic [XLEN-1:0] intRdData;
  logic outValid, outZero;
  logic [XLEN-1:0] outMask;

  always #2.5 clk = ~clk;

  function automatic logic [XLEN-1:0] regVal(int i);
    return 64'h5A3C_0F96_C3A5_1E78 + 64'(i) * 64'h0102_0304_0506_0709;
  endfunction

  assign intRdData = regVal(int'(intRdAddr));

  predMaskLookup dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrIsFp(wrIsFp),
    .wrKey(wrKey), .wrMaskReg(wrMaskReg), .wrInv(wrInv), .wrZero(wrZero),
    .rebuildStart(rebuildStart), .busy(busy), .lkValid(lkValid),
    .lkIsFp(lkIsFp), .lkReg(lkReg), .intRdAddr(intRdAddr),
    .intRdData(intRdData), .outValid(outValid), .outMask(outMask),
    .outZero(outZero)
  );

  int nChk = 0, nFail = 0, cycles = 0;
  bit done = 0;

  // reference model
  bit eFp[NE], eInv[NE], eZero[NE];
  int eKey[NE], eReg[NE];
  bit sEn[64], sInv[64], sZero[64];
  int sReg[64];
  bit mBusy, expValid, expZero;
  int mCur;
  logic [XLEN-1:0] expMask;
  string expTag;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NE; i++) begin
        eFp[i] = 0; eInv[i] = 0; eZero[i] = 0; eKey[i] = 0; eReg[i] = 0;
      end
      for (int s = 0; s < 64; s++) begin
        sEn[s] = 0; sInv[s] = 0; sZero[s] = 0; sReg[s] = 0;
      end
      mBusy = 0; mCur = 0; expValid = 0; expZero = 0; expMask = '0;
    end else begin
      bit wasBusy;
      int k;
      wasBusy = mBusy;
      expValid = lkValid && !wasBusy;
      if (expValid) begin
        k = (lkIsFp ? 32 : 0) + int'(lkReg);
        if (!sEn[k]) begin
          expMask = '1; expZero = 0; expTag = "R6";
        end else begin
          expMask = sInv[k] ? ~regVal(sReg[k]) : regVal(sReg[k]);
          expZero = sZero[k];
          expTag = sInv[k] ? "R8" : "R7";
        end
      end
      if (wasBusy) begin
        k = (eFp[mCur] ? 32 : 0) + eKey[mCur];
        sEn[k] = 1; sReg[k] = eReg[mCur]; sInv[k] = eInv[mCur]; sZero[k] = eZero[mCur];
        mCur++;
        if (mCur == NE) begin mBusy = 0; mCur = 0; end
      end else if (rebuildStart) begin
        for (int s = 0; s < 64; s++) sEn[s] = 0;
        mBusy = 1; mCur = 0;
      end
      if (wrEn && !wasBusy) begin
        eFp[wrIdx] = wrIsFp; eKey[wrIdx] = int'(wrKey); eReg[wrIdx] = int'(wrMaskReg);
        eInv[wrIdx] = wrInv; eZero[wrIdx] = wrZero;
      end
    end
  end

  task automatic chk(string tag, string what, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic tick();
    int k;
    @(negedge clk);
    chk("R3", "busy vs model", 64'(busy), 64'(mBusy));
    chk("R10", "outValid vs model", 64'(outValid), 64'(expValid));
    if (expValid) begin
      chk(expTag, "outMask vs model", outMask, expMask);
      chk("R9", "outZero vs model", 64'(outZero), 64'(expZero));
    end
    k = (lkIsFp ? 32 : 0) + int'(lkReg);
    if (sEn[k]) chk("R7", "intRdAddr vs model", 64'(intRdAddr), 64'(sReg[k]));
  endtask

  task automatic lookup(bit fp, int r, logic [XLEN-1:0] em, bit ez, string tag);
    lkValid = 1; lkIsFp = fp; lkReg = 5'(r);
    tick();
    chk(tag, "lookup valid", 64'(outValid), 64'd1);
    chk(tag, "lookup mask", outMask, em);
    chk(tag, "lookup zero", 64'(outZero), 64'(ez));
    lkValid = 0;
  endtask

  task automatic writeEntry(int idx, bit fp, int key, int mr, bit inv, bit z);
    wrEn = 1; wrIdx = 4'(idx); wrIsFp = fp; wrKey = 5'(key);
    wrMaskReg = 5'(mr); wrInv = inv; wrZero = z;
    tick();
    wrEn = 0;
  endtask

  task automatic rebuild();
    int n = 0;
    rebuildStart = 1;
    tick();
    rebuildStart = 0;
    while (busy && n < 100) begin n++; tick(); end
    chk("R3", "busy cycles", 64'(n), 64'(NE));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    chk("R1", "busy after reset", 64'(busy), 64'd0);
    chk("R1", "outValid after reset", 64'(outValid), 64'd0);
    lookup(0, 3, '1, 0, "R1");
    lookup(1, 0, '1, 0, "R6");

    writeEntry(0, 0, 3, 5, 0, 1);
    writeEntry(1, 1, 3, 7, 1, 0);
    writeEntry(2, 0, 10, 9, 0, 0);
    writeEntry(3, 0, 10, 12, 1, 1);
    lookup(0, 3, '1, 0, "R11");
    rebuild();

    lookup(0, 3, regVal(5), 1, "R7");
    lookup(1, 3, ~regVal(7), 0, "R8");
    lookup(0, 10, ~regVal(12), 1, "R4");
    lookup(1, 10, '1, 0, "R5");
    lookup(0, 0, regVal(0), 0, "R4");
    lookup(0, 20, '1, 0, "R6");

    // second rebuild with writes, restarts and lookups injected while busy
    begin
      int n = 0;
      rebuildStart = 1;
      tick();
      rebuildStart = 0;
      repeat (3) begin n++; tick(); end
      rebuildStart = 1; wrEn = 1; wrIdx = 4'd3; wrIsFp = 0; wrKey = 5'd10;
      wrMaskReg = 5'd20; wrInv = 0; wrZero = 0; lkValid = 1; lkIsFp = 0; lkReg = 5'd3;
      n++; tick();
      chk("R10", "no result while busy", 64'(outValid), 64'd0);
      rebuildStart = 0; wrEn = 0; lkValid = 0;
      while (busy && n < 100) begin n++; tick(); end
      chk("R3", "busy span with restart ignored", 64'(n), 64'(NE));
    end
    lookup(0, 10, ~regVal(12), 1, "R2");

    writeEntry(1, 1, 3, 7, 0, 1);
    lookup(1, 3, ~regVal(7), 0, "R11");
    rebuild();
    lookup(1, 3, regVal(7), 1, "R2");
    lookup(0, 3, regVal(5), 1, "R9");

    // back-to-back sweep of all slots
    for (int s = 0; s < 64; s++) begin
      lkValid = 1; lkIsFp = s[5]; lkReg = 5'(s);
      tick();
    end
    lkValid = 0;
    tick();
    chk("R10", "idle after sweep", 64'(outValid), 64'd0);
    finishRun();
  end
endmodule